// File: doc/BRIEF.md
# Pipelined-ADC Gain Calibration Sequencer

This block is the digital foreground controller that trims the closed-loop gain of the first calibrated stages of a pipelined converter. Each calibrated stage carries a binary-weighted feedback trim capacitor. A trim code selects its value, and the block drives one code per stage. After a start request, the block searches the stages one after another. It begins with the calibrated stage nearest the back end and walks toward the input stage. Every stage that has already finished keeps its code and serves as an ideal gain-of-four stage for the stages searched after it.

Each stage's code is found by a binary search that sets the most significant bit first. A single comparator decision settles each bit. The comparator reports whether the chain output still sits below half the reference, which means the gain is too low. Every bit decision has a fixed time slot: settle cycles first, then one strobe cycle in which the comparator result is taken.

With three stages, 7-bit codes and 8-cycle slots, the whole sequence takes exactly 168 clock cycles. When it ends, the block returns all stages to normal conversion, holds the codes and pulses a done flag.

Top module: `gcal_seq`

## Requirements
- R1: Reset (synchronous, active-low) sets every trim code to mid-scale 1000000b and clears busy, done, the strobe and all calibration enables; a reset in the middle of a run restores the same state.
- R2: A start request is taken only while idle, and busy rises on the next cycle. A start request while busy has no effect on the run's timing or on its results.
- R3: Stages are searched from the highest index to index 0, where index 0 is the input stage. Calibration enable bit i belongs to stage i, and while busy exactly the enable of the stage under search is set.
- R4: When the search of a stage begins, its code is loaded with the trial value 1000000b, whatever it held before.
- R5: Each bit decision takes 8 cycles. The strobe is high only in the last cycle of each slot, and the comparator input is used only in a strobe cycle.
- R6: On a strobe, a comparator input of 1 (gain too low) keeps the trial bit and 0 clears it; the next lower bit then becomes the trial bit, so the code ends as the largest value the comparator still reports as low.
- R7: The codes of stages that are not under search do not change during a run: finished stages keep their results and stages not yet started keep their earlier values.
- R8: Done is a one-cycle pulse that appears 168 clock edges after the edge that accepts start. Busy drops in the same cycle and all calibration enables are clear.
- R9: After done, every code holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Calibration start request |
| cmp_low_i | input | 1 | Comparator: 1 when the chain output is below half the reference |
| trim_code_o | output | NUM_STAGES x CODE_W | Trim code per stage; element i drives stage i |
| cal_en_o | output | NUM_STAGES | Per-stage calibration-mode enable |
| cmp_strobe_o | output | 1 | High in the cycle in which the comparator input is taken |
| busy_o | output | 1 | High while a calibration run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the block with its default values: three stages, 7-bit codes and 8-cycle slots, so every check runs against the 168-cycle budget. Seven bits put both ends of the code range (0 and 127) within reach of a directed target, and three stages give a case in which the factor-of-four deviation scaling of a downstream stage is in play. The comparator model inverts its answer outside the strobe cycle, so any read of the comparator at the wrong time changes a final code.

// File: rtl/gcal_pkg.sv
// Package: shared defaults and types for the gain calibration sequencer.
// Assumes: nothing; it only holds constants and the controller state type.
package gcal_pkg;

    // Default geometry of the calibration run
    localparam int GCAL_STAGES_DEF = 3;
    localparam int GCAL_CODE_W_DEF = 7;
    localparam int GCAL_SLOT_DEF   = 8;

    // Sequencer phase
    typedef enum logic {
        CTRL_IDLE = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_t;

endpackage

// File: rtl/gcal_slot_timer.sv
// Module: gcal_slot_timer
// Divides a run into fixed slots of SLOT_CYCLES cycles and flags the last
// cycle of every slot as the comparator strobe.
// Assumes: SLOT_CYCLES >= 2; run_i is high for whole slots only.
module gcal_slot_timer #(
    parameter int SLOT_CYCLES = 8,
    parameter int CNT_W       = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic strobe_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Cycle position inside the current slot; parked at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST_CNT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Strobe in the final settle cycle of the slot
    always_comb begin
        strobe_o = run_i && (cnt_q == LAST_CNT);
    end

    // R5: a new run always starts at the first cycle of a slot
    a_r5_slot_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (cnt_q == '0));

    // R5: strobes are never back to back
    a_r5_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/gcal_step_ctrl.sv
// Module: gcal_step_ctrl
// Run controller: accepts start while idle and walks the stage index from
// the back end down to stage 0 and the bit index from MSB to LSB, one step
// per strobe. It requests a code load whenever a stage search begins and
// pulses done after the last decision.
// Assumes: strobe_i only arrives while busy_o is high.
module gcal_step_ctrl
    import gcal_pkg::*;
#(
    parameter int NUM_STAGES = 3,
    parameter int CODE_W     = 7,
    parameter int STG_W      = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
    parameter int BIT_W      = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             strobe_i,
    output logic             busy_o,
    output logic [STG_W-1:0] stage_o,
    output logic [BIT_W-1:0] bit_o,
    output logic             load_o,
    output logic [STG_W-1:0] load_idx_o,
    output logic             done_o
);

    localparam logic [STG_W-1:0] TOP_STAGE = STG_W'(NUM_STAGES - 1);
    localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(CODE_W - 1);

    ctrl_state_t      state_q;
    logic [STG_W-1:0] stage_q;
    logic [BIT_W-1:0] bit_q;
    logic             done_q;
    logic             launch;
    logic             stage_end;
    logic             finish;

    // Step events derived from the current position
    always_comb begin
        launch    = (state_q == CTRL_IDLE) && start_i;
        stage_end = (state_q == CTRL_RUN) && strobe_i && (bit_q == '0);
        finish    = stage_end && (stage_q == '0);
    end

    // Phase, stage index, bit index and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTRL_IDLE;
            stage_q <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (launch) begin
                state_q <= CTRL_RUN;
                stage_q <= TOP_STAGE;
                bit_q   <= TOP_BIT;
            end else if (state_q == CTRL_RUN && strobe_i) begin
                if (bit_q != '0) begin
                    bit_q <= bit_q - BIT_W'(1);
                end else if (stage_q != '0) begin
                    stage_q <= stage_q - STG_W'(1);
                    bit_q   <= TOP_BIT;
                end else begin
                    state_q <= CTRL_IDLE;
                end
            end
        end
    end

    // Load request for the stage whose search begins at this edge
    always_comb begin
        load_o     = launch || (stage_end && !finish);
        load_idx_o = launch ? TOP_STAGE : (stage_q - STG_W'(1));
    end

    // Output mapping
    always_comb begin
        busy_o  = (state_q == CTRL_RUN);
        stage_o = stage_q;
        bit_o   = bit_q;
        done_o  = done_q;
    end

    // R2: a run only begins after a start request
    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R8: done lasts exactly one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done coincides with the end of busy
    a_r8_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R3: stage index never walks back up during a run
    a_r3_stage_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (stage_q <= $past(stage_q)));

endmodule

// File: rtl/gcal_sar_reg.sv
// Module: gcal_sar_reg
// Trim code register of one stage with successive-approximation update.
// On load it takes the trial value with only the MSB set; on each decision
// it keeps or clears the current trial bit and sets the next lower one.
// Assumes: load_i and a decision never coincide for the same stage.
module gcal_sar_reg #(
    parameter int CODE_W = 7,
    parameter int BIT_W  = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              active_i,
    input  logic              strobe_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic              cmp_low_i,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] ONE      = {{(CODE_W-1){1'b0}}, 1'b1};

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] trial;
    logic [CODE_W-1:0] decided;

    // Resolve the trial bit and arm the next lower one
    always_comb begin
        trial   = ONE << bit_i;
        decided = (code_q & ~trial) | (cmp_low_i ? trial : '0) | (trial >> 1);
    end

    // Code storage: reset, load or decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID_CODE;
        end else if (load_i) begin
            code_q <= MID_CODE;
        end else if (active_i && strobe_i) begin
            code_q <= decided;
        end
    end

    assign code_o = code_q;

    // R4: a beginning search starts from the MSB trial value
    a_r4_load_mid: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (code_o == MID_CODE));

    // R7: a stage not under search keeps its code
    a_r7_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !active_i) |=> $stable(code_o));

    // R6: bits above the trial bit are final and never change on a decision
    a_r6_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && strobe_i && !load_i)
        |=> ((code_o & ~((ONE << ($past(bit_i) + 1'b1)) - ONE))
             == ($past(code_q) & ~((ONE << ($past(bit_i) + 1'b1)) - ONE))));

endmodule

// File: rtl/gcal_seq.sv
// Module: gcal_seq (top)
// Foreground gain calibration sequencer for the calibrated stages of a
// pipelined converter. Owns the slot timer, the run controller and one
// trim code register per stage; drives the per-stage calibration enables.
// Assumes: cmp_low_i is valid in strobe cycles; stage i is pipeline stage i.
module gcal_seq
    import gcal_pkg::*;
#(
    parameter int NUM_STAGES  = GCAL_STAGES_DEF,
    parameter int CODE_W      = GCAL_CODE_W_DEF,
    parameter int SLOT_CYCLES = GCAL_SLOT_DEF
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic                               cmp_low_i,
    output logic [NUM_STAGES-1:0][CODE_W-1:0]  trim_code_o,
    output logic [NUM_STAGES-1:0]              cal_en_o,
    output logic                               cmp_strobe_o,
    output logic                               busy_o,
    output logic                               done_o
);

    localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
    localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

    logic             busy;
    logic             strobe;
    logic [STG_W-1:0] stage;
    logic [BIT_W-1:0] bit_idx;
    logic             load;
    logic [STG_W-1:0] load_idx;
    logic             done;

    gcal_slot_timer #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (busy),
        .strobe_o (strobe)
    );

    gcal_step_ctrl #(
        .NUM_STAGES (NUM_STAGES),
        .CODE_W     (CODE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .strobe_i   (strobe),
        .busy_o     (busy),
        .stage_o    (stage),
        .bit_o      (bit_idx),
        .load_o     (load),
        .load_idx_o (load_idx),
        .done_o     (done)
    );

    // One trim register and one enable per calibrated stage
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic active;
        logic load_me;

        // Stage selection for this register
        always_comb begin
            active  = busy && (stage == STG_W'(g));
            load_me = load && (load_idx == STG_W'(g));
        end

        gcal_sar_reg #(
            .CODE_W (CODE_W)
        ) u_code (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load_me),
            .active_i  (active),
            .strobe_i  (strobe),
            .bit_i     (bit_idx),
            .cmp_low_i (cmp_low_i),
            .code_o    (trim_code_o[g])
        );

        assign cal_en_o[g] = active;
    end

    // Status outputs
    always_comb begin
        cmp_strobe_o = strobe;
        busy_o       = busy;
        done_o       = done;
    end

    // R3: at most one stage is in calibration mode
    a_r3_single_cal_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cal_en_o));

    // R8: every stage is back in conversion mode when done fires
    a_r8_enables_clear_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cal_en_o == '0));

    // R9: codes hold while idle and no start arrives
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(trim_code_o));

endmodule

// File: tb/gcal_seq_tb_top.sv
`timescale 1ns/1ps
// Directed bench for gcal_seq with a behavioural model of the trimmed chain
// and comparator. Each scenario task checks its own results.
module gcal_seq_tb_top;

    localparam int NS   = 3;
    localparam int CW   = 7;
    localparam int SLOT = 8;
    localparam int RUN  = NS * CW * SLOT;  // 168

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic                    cmp_low_i;
    logic [NS-1:0][CW-1:0]   trim_code_o;
    logic [NS-1:0]           cal_en_o;
    logic                    cmp_strobe_o;
    logic                    busy_o;
    logic                    done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int tgt [NS];

    gcal_seq #(
        .NUM_STAGES  (NS),
        .CODE_W      (CW),
        .SLOT_CYCLES (SLOT)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cmp_low_i    (cmp_low_i),
        .trim_code_o  (trim_code_o),
        .cal_en_o     (cal_en_o),
        .cmp_strobe_o (cmp_strobe_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    always #2.5 clk = ~clk;

    // Chain model: the deviation from half reference scales by four per
    // downstream stage; the answer is inverted outside the strobe cycle.
    always_comb begin
        logic low;
        low = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (cal_en_o[s]) begin
                low = ((tgt[s] - int'(trim_code_o[s])) * (4 ** (NS - 1 - s))) >= 0;
            end
        end
        cmp_low_i = cmp_strobe_o ? low : !low;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: state after reset
    task automatic t_reset();
        do_reset();
        for (int s = 0; s < NS; s++)
            chk(trim_code_o[s] == 7'b1000000, "R1", "reset code", trim_code_o[s], 64);
        chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        chk(cal_en_o == '0, "R1", "reset cal_en", cal_en_o, 0);
        chk(done_o == 1'b0 && cmp_strobe_o == 1'b0, "R1", "reset done/strobe",
            {done_o, cmp_strobe_o}, 0);
    endtask

    // Full run with per-cycle checks; glitch > 0 raises start at that cycle
    task automatic run_cal(input int t2, input int t1, input int t0, input int glitch);
        int prev [NS];
        bit ok_busy = 1, ok_strb = 1, ok_en = 1, ok_done = 1, ok_frz = 1, ok_load = 1;
        int ab = 0, eb = 0, as_ = 0, es = 0, ae = 0, ee = 0, ad = 0, ed = 0;
        int af = 0, ef = 0, al = 0;
        tgt[2] = t2; tgt[1] = t1; tgt[0] = t0;
        for (int s = 0; s < NS; s++) prev[s] = trim_code_o[s];
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= RUN + 7; k++) begin
            bit busy_e, strb_e, done_e;
            int st, en_e;
            @(negedge clk);
            if (k == 1) start_i = 1'b0;
            if (glitch > 0 && k == glitch) start_i = 1'b1;
            if (glitch > 0 && k == glitch + 1) start_i = 1'b0;
            busy_e = (k <= RUN);
            strb_e = busy_e && (k % SLOT == 0);
            done_e = (k == RUN + 1);
            st     = busy_e ? (NS - 1 - ((k - 1) / SLOT) / CW) : -1;
            en_e   = busy_e ? (1 << st) : 0;
            if (busy_o != busy_e && ok_busy) begin ok_busy = 0; ab = busy_o; eb = busy_e; end
            if (cmp_strobe_o != strb_e && ok_strb) begin ok_strb = 0; as_ = k; es = strb_e; end
            if (int'(cal_en_o) != en_e && ok_en) begin ok_en = 0; ae = cal_en_o; ee = en_e; end
            if (done_o != done_e && ok_done) begin ok_done = 0; ad = k; ed = RUN + 1; end
            for (int s = 0; s < NS; s++) begin
                int fe;
                fe = (!busy_e || s > st) ? tgt[s] : prev[s];
                if (s != st && int'(trim_code_o[s]) != fe && ok_frz) begin
                    ok_frz = 0; af = trim_code_o[s]; ef = fe;
                end
            end
            if (busy_e && ((k - 1) % (SLOT * CW) == 0) && trim_code_o[st] != 7'b1000000
                && ok_load) begin
                ok_load = 0; al = trim_code_o[st];
            end
        end
        chk(ok_busy, "R2", "busy window", ab, eb);
        chk(ok_strb, "R5", "strobe timing (cycle)", as_, es);
        chk(ok_en, "R3", "stage enable order", ae, ee);
        chk(ok_done, "R8", "done pulse cycle", ad, ed);
        chk(ok_frz, "R7", "frozen codes", af, ef);
        chk(ok_load, "R4", "stage start code", al, 64);
        for (int s = 0; s < NS; s++)
            chk(int'(trim_code_o[s]) == tgt[s], "R6", "final code", trim_code_o[s], tgt[s]);
        repeat (12) @(negedge clk);
        for (int s = 0; s < NS; s++)
            chk(int'(trim_code_o[s]) == tgt[s], "R9", "held code", trim_code_o[s], tgt[s]);
        chk(!busy_o && cal_en_o == '0, "R9", "idle after run", {busy_o, cal_en_o}, 0);
    endtask

    // R1: reset in the middle of a run restores the reset state
    task automatic t_midrun_reset();
        tgt[2] = 3; tgt[1] = 3; tgt[0] = 3;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b1, "R1", "busy before mid reset", busy_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(trim_code_o[2] == 7'b1000000, "R1", "mid reset code", trim_code_o[2], 64);
        chk(!busy_o && cal_en_o == '0, "R1", "mid reset idle", {busy_o, cal_en_o}, 0);
    endtask

    initial begin
        tgt[0] = 0; tgt[1] = 0; tgt[2] = 0;
        t_reset();
        run_cal(100, 64, 10, 0);       // R6 mixed targets
        run_cal(127, 0, 63, 0);        // R6 range ends
        run_cal(5, 90, 127, 60);       // R2 start while busy
        run_cal(33, 1, 126, 0);        // R4 reload from non-mid codes
        t_midrun_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule